// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block connects a simple synchronous request port to an asynchronous DRAM of 256K words by 8 bits. The DRAM has nine shared address pins, four active-low strobes (row strobe, column strobe, write enable and output enable) and one shared data bus. The controller splits each 18-bit word address into a 9-bit row and a 9-bit column and sequences the strobes. The data bus is handled at pad level through a drive value, a drive enable and a sampled input.

After an access the row stays open, with the row strobe held low. A later request to the same row needs only a new column address and a new column strobe pulse. A request to a different row first raises the row strobe and waits out the precharge time before it opens the new row.

A refresh timer requests one row refresh every `REF_INTERVAL` cycles. With the 200 MHz default this is 3125 cycles, which covers 512 rows in 8 ms. The refresh is row-only: an internal 9-bit counter supplies the row, the row strobe pulses, and the column strobe stays high. A pending refresh closes any open row and goes ahead of new requests. A configuration input selects early writes, where write enable falls before the column strobe, or late writes, where write enable falls while the column strobe is already low.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: Address split. The row is `req_addr_i[17:9]` and must be stable on `dram_addr_o` when `ras_no` falls. The column is `req_addr_i[8:0]` and must be stable on `dram_addr_o` when `cas_no` falls.
- R2: During and directly after reset, `ras_no`, `cas_no`, `we_no` and `oe_no` are high, `dq_oe_o` is low and `rd_valid_o` is low.
- R3: `we_no` and `oe_no` are never low together. `dq_oe_o` is never high while `oe_no` is low.
- R4: Write timing is latched at acceptance. With `late_write_i`=0 (early write), `we_no` falls while `cas_no` is high and is low when `cas_no` falls. With `late_write_i`=1 (late write), `we_no` is high when `cas_no` falls and falls later while `cas_no` is low. The write stores `dq_o` at the selected address.
- R5: For a read, `oe_no` is low and `dq_oe_o` is low when `cas_no` falls. `dq_i` is sampled on the last cycle of the column-strobe-low phase. `rd_valid_o` then pulses for exactly one cycle, with that byte on `rd_data_o`.
- R6: A request to the open row, with no refresh in between, produces a new `cas_no` pulse and no new `ras_no` fall.
- R7: A request to a different row raises `ras_no`, and `ras_no` stays high for at least `T_RP`+1 cycles before the new row opens.
- R8: `cas_no` falls at least `T_RCD`+1 cycles after `ras_no` falls, and stays low for exactly `T_CAS` cycles.
- R9: A refresh is a `ras_no` pulse while `cas_no` stays high. Successive refreshes drive rows 0, 1, 2 and so on, wrapping modulo 512. Refresh starts are `REF_INTERVAL` cycles apart, plus or minus the length of one access.
- R10: A pending refresh goes ahead of new requests. Under continuous requests, the number of refreshes still keeps pace with the elapsed time divided by `REF_INTERVAL`.
- R11: `req_ready_o` is high directly after reset. Each cycle with `req_valid_i` and `req_ready_o` both high starts exactly one DRAM column access.

Top module parameters: `PIN_W`, `DATA_W`, `T_RCD`, `T_CAS`, `T_RP`, `T_RAS`, `REF_INTERVAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| late_write_i | input | 1 | 1 selects late write, 0 selects early write |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address, row in the upper 9 bits |
| req_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | One-cycle read-data strobe |
| rd_data_o | output | 8 | Read data |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | 9 | Shared row/column address pins |
| dq_o | output | 8 | Data driven onto the shared bus |
| dq_oe_o | output | 1 | Data bus drive enable |
| dq_i | input | 8 | Data sampled from the shared bus |

## Verification
The first pattern fills 64 consecutive columns in each of four rows, including rows 0 and 511, and reads them back. Each row uses the opposite write mode from the one before it. This separates page hits from reopened rows, and early from late write-enable ordering, against data computed from the address. The second pattern alternates between two rows on every access, which forces a precharge and a row reopen each time. This distinguishes correct miss handling from a stale open row. An idle stretch at the end, together with refreshes that interrupt both patterns, checks the refresh row sequence, the spacing between refreshes, and the reopen that must follow a refresh that closed the open row.

// File: rtl/fpm_dram_pkg.sv
`timescale 1ns/1ps
package fpm_dram_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_ACT, ST_COLS, ST_CAS, ST_OPEN, ST_PRE, ST_REF_ROW, ST_REF_ACT
  } fpm_state_e;

  // where to go once precharge completes
  typedef enum logic [1:0] {NX_IDLE, NX_ROW, NX_REF} fpm_next_e;
endpackage

// File: rtl/fpm_wait_cnt.sv
`timescale 1ns/1ps
module fpm_wait_cnt #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/fpm_refresh_timer.sv
`timescale 1ns/1ps
module fpm_refresh_timer #(
  parameter int unsigned INTERVAL = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int unsigned TW = $clog2(INTERVAL);

  logic [TW-1:0] tick_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (tick_q == TW'(INTERVAL - 1)) begin
        tick_q <= '0;
        pend_q <= 1'b1;
      end else begin
        tick_q <= tick_q + TW'(1);
        if (ack_i) pend_q <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  // R10
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !ack_i |=> pend_o);
endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
module fpm_dram_ctrl
  import fpm_dram_pkg::*;
#(
  parameter int unsigned PIN_W        = 9,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned T_CAS        = 2,
  parameter int unsigned T_RP         = 2,
  parameter int unsigned T_RAS        = 3,
  parameter int unsigned REF_INTERVAL = 3125  // 8 ms / 512 rows at 200 MHz
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 late_write_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [2*PIN_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 rd_valid_o,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 ras_no,
  output logic                 cas_no,
  output logic                 we_no,
  output logic                 oe_no,
  output logic [PIN_W-1:0]     dram_addr_o,
  output logic [DATA_W-1:0]    dq_o,
  output logic                 dq_oe_o,
  input  logic [DATA_W-1:0]    dq_i
);
  localparam int unsigned ADDR_W = 2 * PIN_W;
  localparam int unsigned T_M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int unsigned T_M2   = (T_RP > T_RAS) ? T_RP : T_RAS;
  localparam int unsigned T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

  fpm_state_e state_q, state_d;
  fpm_next_e  nx_q, nx_d;

  logic [PIN_W-1:0]  row_q, col_q, ref_row_q;
  logic [DATA_W-1:0] wd_q, rd_data_q;
  logic              wr_q, late_q, rd_valid_q;
  logic              accept, hit, ref_pend, ref_ack;
  logic              ld, done, first_cas, in_col, wr_act;
  logic [CNT_W-1:0]  ld_val, cnt;

  fpm_wait_cnt #(.W(CNT_W)) u_wait (
    .clk_i, .rst_ni, .load_i(ld), .val_i(ld_val), .cnt_o(cnt), .done_o(done)
  );

  fpm_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i, .rst_ni, .ack_i(ref_ack), .pend_o(ref_pend)
  );

  assign req_ready_o = (state_q == ST_IDLE || state_q == ST_OPEN) && !ref_pend;
  assign hit         = (req_addr_i[ADDR_W-1:PIN_W] == row_q);

  always_comb begin
    state_d = state_q;
    nx_d    = nx_q;
    ld      = 1'b0;
    ld_val  = '0;
    accept  = 1'b0;
    ref_ack = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) state_d = ST_REF_ROW;
        else if (req_valid_i) begin
          accept  = 1'b1;
          state_d = ST_ROW;
        end
      end
      ST_ROW: begin
        state_d = ST_ACT;
        ld      = 1'b1;
        ld_val  = CNT_W'(T_RCD - 1);
      end
      ST_ACT:  if (done) state_d = ST_COLS;
      ST_COLS: begin
        state_d = ST_CAS;
        ld      = 1'b1;
        ld_val  = CNT_W'(T_CAS - 1);
      end
      ST_CAS:  if (done) state_d = ST_OPEN;
      ST_OPEN: begin
        if (ref_pend) begin
          state_d = ST_PRE;
          nx_d    = NX_REF;
          ld      = 1'b1;
          ld_val  = CNT_W'(T_RP - 1);
        end else if (req_valid_i) begin
          accept = 1'b1;
          if (hit) state_d = ST_COLS;
          else begin
            state_d = ST_PRE;
            nx_d    = NX_ROW;
            ld      = 1'b1;
            ld_val  = CNT_W'(T_RP - 1);
          end
        end
      end
      ST_PRE: begin
        if (done) begin
          unique case (nx_q)
            NX_ROW:  state_d = ST_ROW;
            NX_REF:  state_d = ST_REF_ROW;
            default: state_d = ST_IDLE;
          endcase
        end
      end
      ST_REF_ROW: begin
        state_d = ST_REF_ACT;
        ref_ack = 1'b1;
        ld      = 1'b1;
        ld_val  = CNT_W'(T_RAS - 1);
      end
      ST_REF_ACT: begin
        if (done) begin
          state_d = ST_PRE;
          nx_d    = NX_IDLE;
          ld      = 1'b1;
          ld_val  = CNT_W'(T_RP - 1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      nx_q       <= NX_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      wd_q       <= '0;
      wr_q       <= 1'b0;
      late_q     <= 1'b0;
      ref_row_q  <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      state_q <= state_d;
      nx_q    <= nx_d;
      if (accept) begin
        row_q  <= req_addr_i[ADDR_W-1:PIN_W];
        col_q  <= req_addr_i[PIN_W-1:0];
        wd_q   <= req_wdata_i;
        wr_q   <= req_write_i;
        late_q <= late_write_i;
      end
      if (state_q == ST_REF_ACT && done) ref_row_q <= ref_row_q + PIN_W'(1);
      rd_valid_q <= (state_q == ST_CAS) && done && !wr_q;
      if ((state_q == ST_CAS) && done && !wr_q) rd_data_q <= dq_i;
    end
  end

  assign in_col    = (state_q == ST_COLS) || (state_q == ST_CAS);
  assign first_cas = (state_q == ST_CAS) && (cnt == CNT_W'(T_CAS - 1));
  assign wr_act    = wr_q && in_col;

  assign ras_no  = !(state_q inside {ST_ACT, ST_COLS, ST_CAS, ST_OPEN, ST_REF_ACT});
  assign cas_no  = (state_q != ST_CAS);
  // late write: hold WE high through the column setup and the first CAS-low cycle
  assign we_no   = !(wr_act && (late_q ? (state_q == ST_CAS && !first_cas) : 1'b1));
  assign oe_no   = !(!wr_q && in_col);
  assign dq_oe_o = wr_act;
  assign dq_o    = wd_q;

  always_comb begin
    unique case (state_q)
      ST_COLS, ST_CAS:        dram_addr_o = col_q;
      ST_REF_ROW, ST_REF_ACT: dram_addr_o = ref_row_q;
      default:                dram_addr_o = row_q;
    endcase
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R3
  we_oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no));
  // R3
  dq_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_no);
  // R1
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $stable(dram_addr_o));
  // R1
  col_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> $stable(dram_addr_o));
  // R4
  late_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) && late_q && dq_oe_o |-> we_no);
  // R4
  early_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) && !late_q && dq_oe_o |-> !we_no && $past(!we_no));
  // R7
  pre_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |=> ras_no);
  // R9
  cas_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no);
  // R5
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

// File: tb/fpm_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb_top;
  localparam int PW    = 9;
  localparam int DW    = 8;
  localparam int RCD   = 2;
  localparam int CASW  = 3;
  localparam int RP    = 2;
  localparam int RASW  = 4;
  localparam int REFI  = 300;
  localparam int SLACK = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          late_w, req_valid, req_ready, req_write, rd_valid;
  logic [17:0]   req_addr;
  logic [DW-1:0] req_wdata, rd_data, dq_o, dq_i, model_rd;
  logic          ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [PW-1:0] dram_addr;

  fpm_dram_ctrl #(
    .PIN_W(PW), .DATA_W(DW), .T_RCD(RCD), .T_CAS(CASW), .T_RP(RP), .T_RAS(RASW),
    .REF_INTERVAL(REFI)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .late_write_i(late_w),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .oe_no(oe_n),
    .dram_addr_o(dram_addr), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i)
  );

  function automatic logic [7:0] exp_data(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'hA5;
  endfunction

  // ---------------- DRAM pin model ----------------
  logic [7:0] mem [int];
  logic [PW-1:0] row_l;
  assign dq_i = (!cas_n && !oe_n) ? model_rd : 8'h00;

  always @(negedge cas_n or negedge we_n) begin
    if (!cas_n && !we_n) mem[int'({row_l, dram_addr})] = dq_o;
    if (!cas_n && we_n)
      model_rd = mem.exists(int'({row_l, dram_addr})) ? mem[int'({row_l, dram_addr})] : 8'h00;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // transaction context, owned by the stimulus process
  logic [17:0] cur_addr = '0;
  logic        cur_wr = 1'b0, cur_late = 1'b0;

  // ---------------- row strobe fall ----------------
  int n_fall = 0, t_fall = 0, cas_at_fall = 0, chk_rf = 0, err_rf = 0;
  int n_rise = 0, t_rise = 0, n_ref = 0, t_prev_ref = 0, chk_rr = 0, err_rr = 0;
  int n_cas = 0, t_cas = 0, chk_cf = 0, err_cf = 0, fall_snap = 0, ref_snap = 0;
  logic [PW-1:0] prev_row = '0, exp_ref = '0;
  bit has_prev = 0;

  always @(negedge ras_n) if (rst_n) begin
    row_l = dram_addr;
    cas_at_fall = n_cas;
    t_fall = cyc;
    if (n_rise > 0) begin
      chk_rf++;
      if (cyc - t_rise < RP + 1) begin
        err_rf++;
        $display("FAIL R7 precharge width %0d, expected >= %0d", cyc - t_rise, RP + 1);
      end
    end
    n_fall++;
  end

  // ---------------- row strobe rise ----------------
  always @(posedge ras_n) if (n_fall > 0) begin
    t_rise = cyc;
    if (n_cas == cas_at_fall) begin
      chk_rr++;
      if (row_l !== exp_ref) begin
        err_rr++;
        $display("FAIL R9 refresh row %0d, expected %0d", row_l, exp_ref);
      end
      exp_ref = exp_ref + 9'd1;
      if (n_ref > 0) begin
        chk_rr++;
        if (t_fall - t_prev_ref > REFI + SLACK || t_fall - t_prev_ref < REFI - SLACK) begin
          err_rr++;
          $display("FAIL R9 refresh gap %0d, expected %0d +/- %0d", t_fall - t_prev_ref, REFI, SLACK);
        end
      end
      t_prev_ref = t_fall;
      n_ref++;
    end
    n_rise++;
  end

  // ---------------- column strobe fall ----------------
  always @(negedge cas_n) if (rst_n) begin
    bit reopen_obs, reopen_exp;
    chk_cf++;
    if (ras_n !== 1'b0) begin
      err_cf++;
      $display("FAIL R9 column strobe with row strobe high: ras=%b expected 0", ras_n);
    end
    chk_cf++;
    if ({row_l, dram_addr} !== cur_addr) begin
      err_cf++;
      $display("FAIL R1 captured address %h, expected %h", {row_l, dram_addr}, cur_addr);
    end
    if (n_cas == cas_at_fall) begin
      chk_cf++;
      if (cyc - t_fall < RCD + 1) begin
        err_cf++;
        $display("FAIL R8 row-to-column delay %0d, expected >= %0d", cyc - t_fall, RCD + 1);
      end
    end
    reopen_obs = (n_fall != fall_snap);
    reopen_exp = !has_prev || (cur_addr[17:9] != prev_row) || (n_ref != ref_snap);
    chk_cf++;
    if (reopen_obs != reopen_exp) begin
      err_cf++;
      $display("FAIL R6 row reopen %b, expected %b (addr %h)", reopen_obs, reopen_exp, cur_addr);
    end
    if (cur_wr) begin
      chk_cf++;
      if (we_n !== cur_late) begin
        err_cf++;
        $display("FAIL R4 write enable at column fall %b, expected %b", we_n, cur_late);
      end
    end else begin
      chk_cf++;
      if (oe_n !== 1'b0 || dq_oe !== 1'b0) begin
        err_cf++;
        $display("FAIL R5 oe=%b drive=%b at read column fall, expected 0 0", oe_n, dq_oe);
      end
    end
    prev_row = cur_addr[17:9];
    has_prev = 1;
    fall_snap = n_fall;
    ref_snap = n_ref;
    t_cas = cyc;
    n_cas++;
  end

  // ---------------- column strobe rise ----------------
  int chk_cr = 0, err_cr = 0;
  always @(posedge cas_n) if (n_cas > 0) begin
    chk_cr++;
    if (cyc - t_cas != CASW) begin
      err_cr++;
      $display("FAIL R8 column strobe width %0d, expected %0d", cyc - t_cas, CASW);
    end
  end

  // ---------------- write enable fall ----------------
  int chk_wf = 0, err_wf = 0;
  always @(negedge we_n) if (rst_n) begin
    chk_wf++;
    if (cas_n !== !cur_late) begin
      err_wf++;
      $display("FAIL R4 column strobe at write enable fall %b, expected %b", cas_n, !cur_late);
    end
  end

  // ---------------- bus overlap monitor ----------------
  int viol3 = 0;
  always @(negedge clk) if (rst_n) begin
    if (!we_n && !oe_n) viol3++;
    if (dq_oe && !oe_n) viol3++;
  end

  // ---------------- stimulus ----------------
  int chk_m = 0, err_m = 0, n_acc = 0;
  bit wd_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    chk_m++;
    if (!ok) begin
      err_m++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic do_req(input bit wr, input logic [17:0] a, input bit late);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr  = a;
    cur_wr    = wr;
    cur_late  = late;
    late_w    = late;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = exp_data(a);
    @(negedge clk);
    req_valid = 1'b0;
    n_acc++;
    if (!wr) begin
      for (int i = 0; i < 60 && !rd_valid; i++) @(negedge clk);
      chk(rd_valid === 1'b1 && rd_data === exp_data(a), "R5 read data", int'(rd_data), int'(exp_data(a)));
      @(negedge clk);
      chk(rd_valid === 1'b0, "R5 single-cycle strobe", int'(rd_valid), 0);
    end
  endtask

  task automatic summary(input int extra);
    $display("== %0d vectors applied, %0d miscompares ==",
             chk_m + chk_rf + chk_rr + chk_cf + chk_cr + chk_wf + extra,
             err_m + err_rf + err_rr + err_cf + err_cr + err_wf + extra);
  endtask

  initial begin
    logic [8:0] rows [4];
    rows = '{9'd0, 9'd1, 9'd300, 9'd511};
    late_w = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} === 4'hF, "R2 strobes in reset", int'({ras_n, cas_n, we_n, oe_n}), 15);
    chk(dq_oe === 1'b0 && rd_valid === 1'b0, "R2 bus/strobe in reset", int'({dq_oe, rd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11 ready after reset", int'(req_ready), 1);
    chk({ras_n, cas_n, we_n, oe_n} === 4'hF, "R2 strobes after reset", int'({ras_n, cas_n, we_n, oe_n}), 15);

    // page sweep, write mode alternates per row (R4, R6)
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 64; c++)
        do_req(1'b1, {rows[r], 9'(c)}, r[0]);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 64; c++)
        do_req(1'b0, {rows[r], 9'(c)}, 1'b0);

    // row ping-pong forces a miss on every access (R7)
    for (int c = 0; c < 32; c++) begin
      do_req(1'b1, {9'd5, 9'(c * 7)}, c[1]);
      do_req(1'b1, {9'd400, 9'(c * 7)}, c[0]);
    end
    for (int c = 0; c < 32; c++) begin
      do_req(1'b0, {9'd5, 9'(c * 7)}, 1'b0);
      do_req(1'b0, {9'd400, 9'(c * 7)}, 1'b0);
    end

    // idle stretch: refresh continues alone (R9)
    repeat (2 * REFI + 50) @(negedge clk);

    chk(n_acc == n_cas, "R11 accepted vs column accesses", n_cas, n_acc);
    chk(viol3 == 0, "R3 bus overlap cycles", viol3, 0);
    chk(n_ref >= cyc / REFI - 1, "R10 refresh count", n_ref, cyc / REFI - 1);
    summary(0);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog expired: actual hung expected done");
    summary(1);
    $finish;
  end
endmodule